// File: doc/BRIEF.md
# Byte-Lane Single-Error-Correcting Memory

This block is a synchronous word memory whose 16-bit word is split into two byte lanes, each guarded by its own 4-bit Hamming check field. Every lane keeps a data array and a check array of equal depth. When a lane is written, its byte is encoded and both the byte and the fresh check bits are stored. When a lane is read, a syndrome is recomputed from the stored byte and check bits. A single flipped bit in that lane's 12-bit codeword is repaired before the byte reaches the read data. Because the lanes never share a code, one error in each lane of the same word is repaired in the same read.

Seen from outside, the block behaves like a plain memory with byte enables. There are no error or check-bit pins on the functional interface. Requests enter on a valid-qualified port that is always ready, so the requester sees no back-pressure: a request may be presented on every clock. Read responses come out one clock later, marked by a response-valid strobe that the consumer must take in that cycle. A test-only port XORs a mask into one stored codeword, which lets a bench plant errors. Per-lane debug flags show whether the last read found a nonzero syndrome.

The address width is a parameter. The full-size part uses 19 bits (512K words), and the default is kept small so the design can be elaborated and simulated quickly.

Top module: `bytewise_ecc_ram`

## Requirements
- R1: After reset, rsp_valid, rsp_data and dbg_fix are all zero.
- R2: A request with req_valid high and req_write high stores the enabled byte lanes of req_wdata. Lane 0 is bits 7:0 with enable req_be[0], and lane 1 is bits 15:8 with enable req_be[1]. A request with req_write low is a read. Its word appears on rsp_data in the cycle after the request edge, with rsp_valid high for that one cycle only. Writes and idle cycles give rsp_valid low.
- R3: On a read, a lane whose enable is low returns zero on its byte of rsp_data, and its dbg_fix bit stays low.
- R4: A write leaves the data and check bits of every lane whose enable is low unchanged. An error already planted in such a lane is still corrected by a later read.
- R5: The 12-bit lane codeword has positions 1 to 12. Check bits 0 to 3 sit at positions 1, 2, 4 and 8, and data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. Check bit k is the even parity of the positions whose index has bit k set. Any single flipped bit at any position is corrected on read. Bit k of inj_mask addresses position k+1.
- R6: One flipped bit in each of the two lanes of the same word is corrected in the same read.
- R7: On a read, dbg_fix[i] is high exactly when lane i is enabled and its syndrome is nonzero. This includes an error confined to a check bit, where the returned data equals the stored data.
- R8: A syndrome of 13, 14 or 15 inverts no data bit. The returned byte is the stored byte as it is.
- R9: An injection (inj_en high, lane inj_lane, address inj_addr, mask inj_mask) XORs the mask into that stored codeword at the clock edge. It is ignored in any cycle in which req_valid is high.
- R10: While rsp_valid is low, rsp_data keeps the value of the last read response.
- R11: Writing a lane stores freshly computed check bits, so an error planted earlier in that lane disappears. The next read of that lane shows dbg_fix low.
- R12: The request port never stalls. Reads on consecutive cycles are each answered in the cycle after their own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the response path |
| req_valid | input | 1 | Request present (chip select); always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables, bit i for lane i |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response strobe, one cycle per read |
| rsp_data | output | 16 | Corrected read data; zero in disabled lanes |
| inj_en | input | 1 | Test-only: apply an error mask this cycle |
| inj_lane | input | 1 | Test-only: lane receiving the mask |
| inj_addr | input | ADDR_W | Test-only: word address receiving the mask |
| inj_mask | input | 12 | Test-only: codeword XOR mask, bit k = position k+1 |
| dbg_fix | output | 2 | Debug: per-lane nonzero syndrome on the last read |

## Verification
The assertions watch, on every cycle, the one-cycle response timing and the single-cycle width of rsp_valid. They also check that rsp_data holds between responses, that a disabled lane reads zero with its flag low, and that a decoder never changes more than one data bit. They further check that a syndrome above 12 passes data through unchanged, and that a write and an injection never reach a lane in the same cycle. Whether the repaired value is the value actually written shows only in bench scenarios, because the assertions never see what was written. The same holds for correction at each of the 12 positions, correction of two lanes at once, and the survival of a planted error across a partial write to the other lane.

// File: rtl/becc_pkg.sv
package becc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CHK_W  = 4;
  localparam int unsigned CW_W   = 12;

  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [CHK_W-1:0]  chk_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Parity groups: bit p-1 set when codeword position p has bit k set
  localparam cw_t GRP0 = 12'h555;
  localparam cw_t GRP1 = 12'h666;
  localparam cw_t GRP2 = 12'h878;
  localparam cw_t GRP3 = 12'hF80;

  // Place data and check bits at their codeword positions (12 down to 1)
  function automatic cw_t cw_pack(input byte_t d, input chk_t c);
    return {d[7], d[6], d[5], d[4], c[3], d[3], d[2], d[1], c[2], d[0], c[1], c[0]};
  endfunction

  function automatic byte_t cw_data(input cw_t cw);
    return {cw[11], cw[10], cw[9], cw[8], cw[6], cw[5], cw[4], cw[2]};
  endfunction

  function automatic chk_t cw_chk(input cw_t cw);
    return {cw[7], cw[3], cw[1], cw[0]};
  endfunction

  function automatic chk_t cw_syndrome(input cw_t cw);
    return {^(cw & GRP3), ^(cw & GRP2), ^(cw & GRP1), ^(cw & GRP0)};
  endfunction

  // Check positions are zero in the packed word, so the syndrome is the parity set
  function automatic chk_t byte_encode(input byte_t d);
    return cw_syndrome(cw_pack(d, '0));
  endfunction
endpackage

// File: rtl/ecc_lane_store.sv
module ecc_lane_store
  import becc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  cw_t               inj_mask,
  output byte_t             rd_byte,
  output chk_t              rd_chk
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  byte_t dmem [DEPTH];
  chk_t  cmem [DEPTH];

  // Write path: fresh encode on write; test mask otherwise
  always_ff @(posedge clk) begin
    if (wr_en) begin
      dmem[addr] <= wdata;
      cmem[addr] <= byte_encode(wdata);
    end else if (inj_en) begin
      dmem[inj_addr] <= dmem[inj_addr] ^ cw_data(inj_mask);
      cmem[inj_addr] <= cmem[inj_addr] ^ cw_chk(inj_mask);
    end
  end

  // Registered raw read of both arrays
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_byte <= '0;
      rd_chk  <= '0;
    end else if (rd_en) begin
      rd_byte <= dmem[addr];
      rd_chk  <= cmem[addr];
    end
  end

  AST_WR_INJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && inj_en)); // R9
  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(rd_byte) && $stable(rd_chk))); // R10
endmodule

// File: rtl/ecc_lane_fix.sv
module ecc_lane_fix
  import becc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  byte_t din,
  input  chk_t  cin,
  output byte_t dout,
  output logic  fix
);
  cw_t   raw;
  chk_t  syn;
  cw_t   flip;
  byte_t good;

  always_comb begin
    raw  = cw_pack(din, cin);
    syn  = cw_syndrome(raw);
    flip = '0;
    if (syn != '0 && syn <= 4'd12) flip = cw_t'(1) << (syn - 4'd1);
    good = cw_data(raw ^ flip);
    dout = en ? good : '0;
    fix  = en && (syn != '0);
  end

  AST_ONE_FLIP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(dout ^ din) <= 1)); // R5
  AST_OFF_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (dout == '0 && !fix)); // R3
  AST_HIGH_SYN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && syn > 4'd12) |-> (dout == din)); // R8
endmodule

// File: rtl/bytewise_ecc_ram.sv
module bytewise_ecc_ram
  import becc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [LANES-1:0]         req_be,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LANES*BYTE_W-1:0]  req_wdata,
  output logic                     rsp_valid,
  output logic [LANES*BYTE_W-1:0]  rsp_data,
  input  logic                     inj_en,
  input  logic [$clog2(LANES)-1:0] inj_lane,
  input  logic [ADDR_W-1:0]        inj_addr,
  input  logic [CW_W-1:0]          inj_mask,
  output logic [LANES-1:0]         dbg_fix
);
  localparam int unsigned LSEL_W = $clog2(LANES);

  logic             rd_fire;
  logic             wr_fire;
  logic             inj_ok;
  logic [LANES-1:0] be_q;

  assign rd_fire = req_valid && !req_write;
  assign wr_fire = req_valid && req_write;
  assign inj_ok  = inj_en && !req_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      be_q      <= '0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) be_q <= req_be;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    byte_t raw_byte;
    chk_t  raw_chk;

    ecc_lane_store #(.ADDR_W(ADDR_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_fire && req_be[g]),
      .rd_en    (rd_fire && req_be[g]),
      .addr     (req_addr),
      .wdata    (req_wdata[g*BYTE_W +: BYTE_W]),
      .inj_en   (inj_ok && (inj_lane == LSEL_W'(g))),
      .inj_addr (inj_addr),
      .inj_mask (inj_mask),
      .rd_byte  (raw_byte),
      .rd_chk   (raw_chk)
    );

    ecc_lane_fix u_fix (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (be_q[g]),
      .din   (raw_byte),
      .cin   (raw_chk),
      .dout  (rsp_data[g*BYTE_W +: BYTE_W]),
      .fix   (dbg_fix[g])
    );
  end

  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (rsp_valid == $past(rd_fire))); // R2
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_data)); // R10
  AST_FIX_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    ((dbg_fix != '0) && !rsp_valid) |-> $stable(dbg_fix)); // R7
  AST_B2B_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid); // R12
endmodule

// File: tb/sim_bytewise_ecc_ram.sv
module sim_bytewise_ecc_ram;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid, req_write;
  logic [1:0]    req_be;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic          rsp_valid;
  logic [15:0]   rsp_data;
  logic          inj_en;
  logic          inj_lane;
  logic [AW-1:0] inj_addr;
  logic [11:0]   inj_mask;
  logic [1:0]    dbg_fix;

  always #10 clk = ~clk;

  bytewise_ecc_ram #(.ADDR_W(AW), .LANES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .inj_en(inj_en),
    .inj_lane(inj_lane), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .dbg_fix(dbg_fix)
  );

  logic [15:0] model [DEPTH];
  logic [1:0]  dirty [DEPTH];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [15:0] lane_bits(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // Data bit carried at codeword position p (R5 layout), or -1 for a check position
  function automatic int pos_to_dbit(input int p);
    case (p)
      3: return 0;  5: return 1;  6: return 2;  7: return 3;
      9: return 4; 10: return 5; 11: return 6; 12: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    req_valid = 1'b0; req_write = 1'b0; req_be = '0; req_addr = '0; req_wdata = '0;
    inj_en = 1'b0; inj_lane = 1'b0; inj_addr = '0; inj_mask = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] be, input logic [15:0] d);
    logic [15:0] m;
    m = lane_bits(be);
    req_valid = 1'b1; req_write = 1'b1; req_be = be; req_addr = a; req_wdata = d;
    @(negedge clk);
    go_idle();
    model[a] = (model[a] & ~m) | (d & m);
    dirty[a] = dirty[a] & ~be;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] be, input string req);
    req_valid = 1'b1; req_write = 1'b0; req_be = be; req_addr = a;
    @(negedge clk);
    go_idle();
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " rsp_data"}, 32'(rsp_data), 32'(model[a] & lane_bits(be)));
    check({req, " dbg_fix"}, 32'(dbg_fix), 32'(dirty[a] & be));
  endtask

  // Single-bit injection at codeword position p; the model keeps the good data
  task automatic inj1(input logic [AW-1:0] a, input logic lane, input int p);
    inj_en = 1'b1; inj_lane = lane; inj_addr = a; inj_mask = 12'(1) << (p - 1);
    @(negedge clk);
    go_idle();
    dirty[a][lane] = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev;
    logic [15:0] d16;
    void'($urandom(32'd20240611));
    go_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 rsp_data", 32'(rsp_data), 32'd0);
    check("R1 dbg_fix", 32'(dbg_fix), 32'd0);

    for (int a = 0; a < DEPTH; a++) begin
      dirty[a] = 2'b00;
      model[a] = 16'h0000;
      wr(AW'(a), 2'b11, 16'($urandom));
    end
    check("R2 no rsp after write", 32'(rsp_valid), 32'd0);

    // R2 round trips on directed patterns
    wr(10'd1, 2'b11, 16'hA55A); rd(10'd1, 2'b11, "R2 pattern A55A");
    wr(10'd2, 2'b11, 16'hFFFF); rd(10'd2, 2'b11, "R2 pattern FFFF");
    wr(10'd3, 2'b11, 16'h0000); rd(10'd3, 2'b11, "R2 pattern 0000");
    @(negedge clk);
    check("R2 single-cycle strobe", 32'(rsp_valid), 32'd0);

    // R3 disabled lanes read zero
    rd(10'd1, 2'b01, "R3 lower only");
    rd(10'd1, 2'b10, "R3 upper only");
    rd(10'd1, 2'b00, "R3 no lane");

    // R10 hold while idle
    rd(10'd2, 2'b11, "R10 setup");
    prev = rsp_data;
    @(negedge clk);
    check("R10 hold valid", 32'(rsp_valid), 32'd0);
    check("R10 hold data", 32'(rsp_data), 32'(prev));

    // R5 every position in both lanes
    for (int lane = 0; lane < 2; lane++) begin
      for (int p = 1; p <= 12; p++) begin
        wr(10'd9, 2'b11, 16'($urandom));
        inj1(10'd9, lane[0], p);
        rd(10'd9, 2'b11, (pos_to_dbit(p) < 0) ? "R7 check-bit error" : "R5 single error");
      end
    end
    wr(10'd9, 2'b11, 16'h1234);

    // R6 one error per lane in one word
    inj1(10'd11, 1'b0, 5);
    inj1(10'd11, 1'b1, 12);
    rd(10'd11, 2'b11, "R6 both lanes");

    // R4 partial write keeps the other lane's codeword; R11 rewrite clears error
    inj1(10'd13, 1'b1, 6);
    wr(10'd13, 2'b01, 16'h00C3);
    rd(10'd13, 2'b11, "R4 partial write");
    wr(10'd13, 2'b10, 16'h7E00);
    rd(10'd13, 2'b11, "R11 re-encode");
    inj1(10'd15, 1'b0, 3);
    wr(10'd15, 2'b11, 16'hBEEF);
    rd(10'd15, 2'b11, "R11 full rewrite");

    // R7 check-bit-only error: data intact, flag raised
    inj1(10'd7, 1'b0, 4);
    rd(10'd7, 2'b01, "R7 check bit 4");

    // R8 positions 12 and 1 flipped: syndrome 13, no correction
    inj_en = 1'b1; inj_lane = 1'b1; inj_addr = 10'd5; inj_mask = 12'h801;
    @(negedge clk);
    go_idle();
    model[5] = model[5] ^ 16'h8000;
    dirty[5][1] = 1'b1;
    rd(10'd5, 2'b11, "R8 syndrome 13");
    wr(10'd5, 2'b11, 16'h5A5A);
    rd(10'd5, 2'b11, "R8 restored");

    // R9 injection ignored while a request is present
    req_valid = 1'b1; req_write = 1'b0; req_be = 2'b11; req_addr = 10'd20;
    inj_en = 1'b1; inj_lane = 1'b0; inj_addr = 10'd20; inj_mask = 12'h004;
    @(negedge clk);
    go_idle();
    check("R9 read during inject", 32'(rsp_data), 32'(model[20]));
    rd(10'd20, 2'b11, "R9 inject ignored");

    // R12 back-to-back reads
    req_valid = 1'b1; req_write = 1'b0; req_be = 2'b11; req_addr = 10'd1;
    @(negedge clk);
    check("R12 first rsp_valid", 32'(rsp_valid), 32'd1);
    check("R12 first data", 32'(rsp_data), 32'(model[1]));
    req_addr = 10'd2;
    @(negedge clk);
    go_idle();
    check("R12 second rsp_valid", 32'(rsp_valid), 32'd1);
    check("R12 second data", 32'(rsp_data), 32'(model[2]));

    // Random mix of writes, reads and single-bit injections
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      logic [1:0] be;
      int op;
      a  = AW'($urandom);
      be = 2'($urandom);
      op = int'($urandom % 4);
      if (op == 0) begin
        d16 = 16'($urandom);
        wr(a, be, d16);
      end else if (op == 3) begin
        logic ln;
        ln = 1'($urandom);
        if (!dirty[a][ln]) inj1(a, ln, int'($urandom % 12) + 1);
      end else begin
        rd(a, be, "R5 random read");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule